// File: doc/BRIEF.md
# Serial Slave Port with Shared Result-Ready Line

This block is the host-side serial port of a converter front end. It acts as a four-wire SPI slave, mode 0 (SCLK idles low, the master samples on the rising edge). The master sends an 8-bit command. If the command asks for the result, the slave then returns the latest 16-bit conversion value on MISO over the next sixteen SCLK pulses. The converter side delivers each new value with a one-cycle strobe, and the block copies it into a holding register at that moment.

A configuration input chooses how MISO behaves while no result bits are being shifted. In plain mode the line is driven low. In shared mode it carries an active-low "result ready" level, so a falling edge on MISO tells the master that a fresh value is waiting. When a new result arrives while the shared line is already low, the block lifts the line high for a few cycles and drops it again. This re-creates the falling edge. Any command other than the result read returns the line high, so the master can poll it for a zero. A separate READY output always shows the same information with the opposite polarity, whatever the configuration.

All serial inputs are brought into the system clock domain through flop chains, and all outputs change on the system clock.

Top module: `spi_ready_slave`

## Requirements
- R1: MISO's output enable (`miso_oe`) is 0 while SS (`ss_n`) is high, in both modes; it is 1 while `ss_n` is low.
- R2: `cfg_combined` affects only what MISO shows; toggling it never changes `ready`.
- R3: After command 0x01 (result read, MSB first on MOSI), the next 16 SCLK pulses put the held result on MISO from D15 down to D0: high byte on pulses 1 to 8, low byte on pulses 9 to 16. Each bit is valid at its rising edge and changes on the falling edge.
- R4: In shared mode (`cfg_combined`=1), a conversion strobe while the ready line is high drives MISO low (outside data bits) and drives `ready` to 1.
- R5: A conversion strobe while the ready line is already low lifts the line high (`ready` 0) for exactly REARM_CYC system cycles (default 2), then drives it low again (`ready` 1).
- R6: Any completed command other than 0x01, such as NOP 0x00 or 0x5A, forces the ready line high: `ready` becomes 0 and shared-mode idle MISO becomes 1.
- R7: The result-read command 0x01 leaves the ready level unchanged.
- R8: The result is captured at the strobe. A strobe during a read frame does not alter the bits of that frame, and the next read returns the new value.
- R9: In plain mode (`cfg_combined`=0), MISO is 0 while SS is low and no result bits are being shifted.
- R10: After reset the ready line is high (`ready`=0) and `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_combined | input | 1 | 1 = MISO doubles as active-low ready line, 0 = plain data output |
| ss_n | input | 1 | Slave select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from master, asynchronous to clk |
| mosi | input | 1 | Serial command data from master |
| eoc_strobe | input | 1 | One-cycle pulse: a conversion result is valid |
| eoc_data | input | DATA_W | Conversion result, sampled with `eoc_strobe` |
| miso | output | 1 | Serial data out / shared ready level |
| miso_oe | output | 1 | Output enable for the MISO tri-state driver |
| ready | output | 1 | Result-available flag, opposite polarity to the shared line |

## Verification
The assertions assume that `ss_n`, `sclk` and `mosi` change slowly compared with the system clock. SCLK half-periods and SS setup must last several clk cycles, so that every serial edge survives the two-flop synchronizers as a distinct event. They also assume the strobe is a single-cycle pulse in the clk domain. The stimulus respects this by holding each SCLK level for six system cycles and waiting that long around SS transitions. It drives the strobe for exactly one cycle from the falling clock edge, and issues strobes mid-frame only between SCLK edges.

// File: rtl/spi_ready_pkg.sv
`timescale 1ns/1ps
// Package: shared types and default opcodes for the serial slave port.
package spi_ready_pkg;

    // Level of the shared ready line: high idle, low pending, or high re-arm pulse.
    typedef enum logic [1:0] {
        LINE_HIGH  = 2'd0,
        LINE_LOW   = 2'd1,
        LINE_REARM = 2'd2
    } line_state_e;

    localparam logic [7:0] OPC_NOP  = 8'h00;
    localparam logic [7:0] OPC_READ = 8'h01;

endpackage

// File: rtl/spi_sync_bit.sv
`timescale 1ns/1ps
// Module: spi_sync_bit
// Brings one asynchronous input into the clk domain through a flop chain.
// Assumes STAGES >= 2. RST_VAL is the idle level of the input.
module spi_sync_bit #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the raw input through the chain; reset loads the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_cmd_decode.sv
`timescale 1ns/1ps
// Module: spi_cmd_decode
// Collects a CMD_W-bit command from MOSI on synchronized SCLK rising edges,
// MSB first, while the slave is selected and no result is being shifted.
// When the last bit arrives, it pulses read_load if the command is OP_READ,
// and cmd_clear for every other command.
// Assumes CMD_W >= 3 and clean single-cycle edge pulses.
module spi_cmd_decode #(
    parameter int               CMD_W   = 8,
    parameter logic [CMD_W-1:0] OP_READ = 8'h01
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_act,
    input  logic sclk_rise,
    input  logic mosi_s,
    input  logic busy,
    output logic read_load,
    output logic cmd_clear
);

    localparam int CNT_W = $clog2(CMD_W);

    logic [CMD_W-2:0] cmd_sr;
    logic [CNT_W-1:0] bit_cnt;
    logic [CMD_W-1:0] cmd_full;

    assign cmd_full = {cmd_sr, mosi_s};

    // Shift command bits, count them, and decode on the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_sr    <= '0;
            bit_cnt   <= '0;
            read_load <= 1'b0;
            cmd_clear <= 1'b0;
        end else begin
            read_load <= 1'b0;
            cmd_clear <= 1'b0;
            if (!ss_act) begin
                bit_cnt <= '0;
            end else if (sclk_rise && !busy) begin
                cmd_sr <= cmd_full[CMD_W-2:0];
                if (bit_cnt == CNT_W'(CMD_W-1)) begin
                    bit_cnt <= '0;
                    if (cmd_full == OP_READ) begin
                        read_load <= 1'b1;
                    end else begin
                        cmd_clear <= 1'b1;
                    end
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_tx_shift.sv
`timescale 1ns/1ps
// Module: spi_tx_shift
// Output shift register for the result word. On load it presents the MSB at
// once. It skips the first falling edge (the one closing the command byte),
// then shifts on each later falling edge. The data phase ends after DATA_W
// rising edges, or when the slave is deselected.
// Assumes rise and fall pulses never coincide.
module spi_tx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              active_o,
    output logic              bit_o
);

    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] tx_sr;
    logic [CNT_W-1:0]  rise_cnt;
    logic              skip_fall;

    // Load, shift on falling edges, and count rising edges of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr     <= '0;
            rise_cnt  <= '0;
            skip_fall <= 1'b0;
            active_o  <= 1'b0;
        end else if (!ss_act) begin
            tx_sr     <= '0;
            rise_cnt  <= '0;
            skip_fall <= 1'b0;
            active_o  <= 1'b0;
        end else if (load) begin
            tx_sr     <= load_data;
            rise_cnt  <= '0;
            skip_fall <= 1'b1;
            active_o  <= 1'b1;
        end else if (active_o) begin
            if (sclk_fall) begin
                if (skip_fall) begin
                    skip_fall <= 1'b0;
                end else begin
                    tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                end
            end
            if (sclk_rise) begin
                if (rise_cnt == CNT_W'(DATA_W-1)) begin
                    rise_cnt <= '0;
                    active_o <= 1'b0;
                end else begin
                    rise_cnt <= rise_cnt + 1'b1;
                end
            end
        end
    end

    assign bit_o = tx_sr[DATA_W-1];

endmodule

// File: rtl/spi_ready_line.sv
`timescale 1ns/1ps
// Module: spi_ready_line
// Holds the level of the shared ready line (1 = nothing pending).
// A strobe from high drives it low. A strobe while low (or re-arming) lifts
// it high for REARM_CYC cycles and then drops it, so a new falling edge
// appears. A clear request returns it high. A strobe outranks a clear.
// Assumes REARM_CYC >= 1.
module spi_ready_line
    import spi_ready_pkg::*;
#(
    parameter int REARM_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        eoc,
    input  logic        clr,
    output line_state_e state_o,
    output logic        line_o
);

    localparam int CW = (REARM_CYC > 1) ? $clog2(REARM_CYC) : 1;

    logic [CW-1:0] hold_cnt;

    // Advance the line state on strobes, clears and re-arm countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o  <= LINE_HIGH;
            hold_cnt <= '0;
        end else if (eoc) begin
            if (state_o == LINE_HIGH) begin
                state_o <= LINE_LOW;
            end else begin
                state_o  <= LINE_REARM;
                hold_cnt <= CW'(REARM_CYC-1);
            end
        end else if (clr) begin
            state_o <= LINE_HIGH;
        end else if (state_o == LINE_REARM) begin
            if (hold_cnt == '0) begin
                state_o <= LINE_LOW;
            end else begin
                hold_cnt <= hold_cnt - 1'b1;
            end
        end
    end

    assign line_o = (state_o != LINE_LOW);

endmodule

// File: rtl/spi_ready_slave.sv
`timescale 1ns/1ps
// Module: spi_ready_slave (top)
// Four-wire serial slave returning a conversion result on command. MISO can
// double as an active-low result-ready line, and a separate READY output
// shows the same flag with the opposite polarity.
// Assumes ss_n, sclk and mosi are slow relative to clk (several clk cycles
// per level) and eoc_strobe is a single-cycle pulse in the clk domain.
module spi_ready_slave
    import spi_ready_pkg::*;
#(
    parameter int               DATA_W      = 16,
    parameter int               CMD_W       = 8,
    parameter int               SYNC_STAGES = 2,
    parameter int               REARM_CYC   = 2,
    parameter logic [CMD_W-1:0] OP_READ     = CMD_W'(OPC_READ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_combined,
    input  logic              ss_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              eoc_strobe,
    input  logic [DATA_W-1:0] eoc_data,
    output logic              miso,
    output logic              miso_oe,
    output logic              ready
);

    localparam int             N_SYNC   = 3;
    localparam logic [N_SYNC-1:0] SYNC_RST = 3'b100;

    logic [N_SYNC-1:0] async_vec;
    logic [N_SYNC-1:0] sync_vec;
    logic              sclk_prev;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              ss_act;
    logic [DATA_W-1:0] hold_q;
    logic              read_load;
    logic              cmd_clear;
    logic              tx_active;
    logic              tx_bit;
    logic              ready_line;
    line_state_e       rdy_state;

    assign async_vec = {ss_n, sclk, mosi};

    // One synchronizer per serial input; SS idles high, the others low.
    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        spi_sync_bit #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (SYNC_RST[g])
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (async_vec[g]),
            .q       (sync_vec[g])
        );
    end

    assign ss_act = ~sync_vec[2];

    // Remember the previous synchronized SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sync_vec[1];
        end
    end

    assign sclk_rise = sync_vec[1] & ~sclk_prev;
    assign sclk_fall = ~sync_vec[1] & sclk_prev;

    // Capture each conversion result when its strobe fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (eoc_strobe) begin
            hold_q <= eoc_data;
        end
    end

    spi_cmd_decode #(
        .CMD_W   (CMD_W),
        .OP_READ (OP_READ)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_act    (ss_act),
        .sclk_rise (sclk_rise),
        .mosi_s    (sync_vec[0]),
        .busy      (tx_active),
        .read_load (read_load),
        .cmd_clear (cmd_clear)
    );

    spi_tx_shift #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_act    (ss_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .load      (read_load),
        .load_data (hold_q),
        .active_o  (tx_active),
        .bit_o     (tx_bit)
    );

    spi_ready_line #(
        .REARM_CYC (REARM_CYC)
    ) u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .eoc     (eoc_strobe),
        .clr     (cmd_clear),
        .state_o (rdy_state),
        .line_o  (ready_line)
    );

    // Pin drive: data bits while shifting, otherwise ready level or zero.
    always_comb begin
        miso_oe = ss_act;
        if (tx_active) begin
            miso = tx_bit;
        end else begin
            miso = cfg_combined & ready_line;
        end
        ready = ~ready_line;
    end

endmodule

// File: rtl/spi_ready_slave_chk.sv
`timescale 1ns/1ps
// Module: spi_ready_slave_chk
// Property checker bound into spi_ready_slave. It relates the pins to the
// ready-line state and to the command decoder's pulses.
module spi_ready_slave_chk
    import spi_ready_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ss_n,
    input  logic        eoc_strobe,
    input  logic        miso_oe,
    input  logic        ready,
    input  logic        read_load,
    input  logic        cmd_clear,
    input  line_state_e rdy_state
);

    logic [1:0] since_rst;

    // Count cycles since reset, saturating, to guard $past look-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // R1: SS held high through the synchronizer keeps MISO undriven.
    a_r1_float_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(ss_n, 1) && $past(ss_n, 2)) |-> !miso_oe);

    // R4: strobe with line high raises ready next cycle.
    a_r4_strobe_from_high: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_strobe && rdy_state == LINE_HIGH) |=> ready);

    // R5: strobe while pending lifts the line (ready low) next cycle.
    a_r5_strobe_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_strobe && rdy_state != LINE_HIGH) |=> !ready);

    // R6: a non-read command drops ready unless a strobe coincides.
    a_r6_clear_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clear && !eoc_strobe) |=> !ready);

    // R7: a read command leaves a settled ready level alone.
    a_r7_read_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (read_load && !eoc_strobe && rdy_state != LINE_REARM) |=> $stable(ready));

    // R6/R7: the decoder never issues both outcomes at once.
    a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(read_load && cmd_clear));

endmodule

bind spi_ready_slave spi_ready_slave_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ss_n       (ss_n),
    .eoc_strobe (eoc_strobe),
    .miso_oe    (miso_oe),
    .ready      (ready),
    .read_load  (read_load),
    .cmd_clear  (cmd_clear),
    .rdy_state  (rdy_state)
);

// File: tb/spi_ready_slave_tb_top.sv
`timescale 1ns/1ps
// Bench: drives mode-0 frames slowly, sweeps result patterns, and checks
// ready-line behaviour at the pins against values computed here.
module spi_ready_slave_tb_top;

    localparam int DATA_W    = 16;
    localparam int REARM_CYC = 2;
    localparam int HALF      = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_combined = 1'b1;
    logic              ss_n = 1'b1;
    logic              sclk = 1'b0;
    logic              mosi = 1'b0;
    logic              eoc_strobe = 1'b0;
    logic [DATA_W-1:0] eoc_data = '0;
    logic              miso;
    logic              miso_oe;
    logic              ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int low_run = 0;
    int last_low_run = 0;

    always #2.5 clk = ~clk;

    spi_ready_slave #(.DATA_W(DATA_W), .REARM_CYC(REARM_CYC)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_combined (cfg_combined),
        .ss_n         (ss_n),
        .sclk         (sclk),
        .mosi         (mosi),
        .eoc_strobe   (eoc_strobe),
        .eoc_data     (eoc_data),
        .miso         (miso),
        .miso_oe      (miso_oe),
        .ready        (ready)
    );

    // Measure how long ready stays low before each rise (for R5).
    always @(negedge clk) begin
        if (ready == 1'b0) begin
            low_run = low_run + 1;
        end else begin
            if (low_run > 0) last_low_run = low_run;
            low_run = 0;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_eoc(input logic [DATA_W-1:0] v);
        @(negedge clk);
        eoc_data   = v;
        eoc_strobe = 1'b1;
        @(negedge clk);
        eoc_strobe = 1'b0;
    endtask

    // One frame: 8 command bits, then nd data pulses; optional strobe mid-data.
    task automatic frame(input logic [7:0] op, input int nd, input bit mid_eoc,
                         input logic [DATA_W-1:0] mid_val, output logic [DATA_W-1:0] rd);
        rd = '0;
        ss_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 8; i++) begin
            mosi = op[7-i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        for (int i = 0; i < nd; i++) begin
            wait_clk(HALF);
            if (mid_eoc && i == 8) pulse_eoc(mid_val);
            rd = {rd[DATA_W-2:0], miso};
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        ss_n = 1'b1;
        wait_clk(2*HALF);
    endtask

    // Select the slave without clocks and report idle MISO.
    task automatic idle_miso(output logic m, output logic oe);
        ss_n = 1'b0;
        wait_clk(8);
        m  = miso;
        oe = miso_oe;
        ss_n = 1'b1;
        wait_clk(8);
    endtask

    initial begin
        logic [DATA_W-1:0] rd;
        logic [DATA_W-1:0] pat;
        logic m, oe;
        int rise_ref;

        wait_clk(5);
        // R10: reset state
        chk("R10 oe after reset", miso_oe, 0);
        chk("R10 ready after reset", ready, 0);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R10 ready low after release", ready, 0);
        idle_miso(m, oe);
        chk("R10 shared idle line high", m, 1);
        chk("R1 oe with ss low", oe, 1);
        chk("R1 oe with ss high (shared)", miso_oe, 0);

        // R4: strobe from high
        ss_n = 1'b0;
        wait_clk(8);
        pulse_eoc(16'hA5C3);
        wait_clk(4);
        chk("R4 shared miso low", miso, 0);
        chk("R4 ready high", ready, 1);

        // R5: strobe while low re-arms
        pulse_eoc(16'h1234);
        wait_clk(10);
        chk("R5 high pulse length", last_low_run, REARM_CYC);
        chk("R5 ready back high", ready, 1);
        chk("R5 miso back low", miso, 0);
        ss_n = 1'b1;
        wait_clk(8);

        // R3/R7: read the result; ready unchanged
        frame(8'h01, 16, 1'b0, '0, rd);
        chk("R3 read value", rd, 16'h1234);
        chk("R7 ready kept after read", ready, 1);
        idle_miso(m, oe);
        chk("R7 shared idle still low", m, 0);

        // R6: NOP and another non-read opcode clear the line
        frame(8'h00, 0, 1'b0, '0, rd);
        chk("R6 NOP clears ready", ready, 0);
        idle_miso(m, oe);
        chk("R6 NOP shared idle high", m, 1);
        pulse_eoc(16'h0F0F);
        wait_clk(4);
        chk("R4 ready set again", ready, 1);
        frame(8'h5A, 0, 1'b0, '0, rd);
        chk("R6 opcode 5A clears ready", ready, 0);

        // R3: walking one and walking zero patterns
        for (int k = 0; k < 2*DATA_W; k++) begin
            pat = (k < DATA_W) ? (DATA_W'(1) << k) : ~(DATA_W'(1) << (k - DATA_W));
            pulse_eoc(pat);
            frame(8'h01, 16, 1'b0, '0, rd);
            chk("R3 pattern sweep", rd, pat);
        end

        // R2/R9: configuration bit changes only MISO
        chk("R2 ready before toggle", ready, 1);
        cfg_combined = 1'b0;
        wait_clk(4);
        chk("R2 ready unchanged by cfg", ready, 1);
        idle_miso(m, oe);
        chk("R9 plain idle miso low", m, 0);
        chk("R1 oe plain selected", oe, 1);
        chk("R1 oe plain deselected", miso_oe, 0);
        pulse_eoc(16'hBEEF);
        frame(8'h01, 16, 1'b0, '0, rd);
        chk("R3 plain-mode read", rd, 16'hBEEF);
        rise_ref = last_low_run;
        frame(8'h00, 0, 1'b0, '0, rd);
        chk("R2 plain NOP clears ready", ready, 0);
        cfg_combined = 1'b1;
        wait_clk(4);
        chk("R2 ready unchanged back to shared", ready, 0);
        idle_miso(m, oe);
        chk("R6 shared idle high after plain NOP", m, 1);
        chk("R5 no spurious pulse", last_low_run, rise_ref);

        // R8: strobe mid-frame does not corrupt the frame
        pulse_eoc(16'h1111);
        frame(8'h01, 16, 1'b1, 16'h2222, rd);
        chk("R8 frame keeps captured value", rd, 16'h1111);
        frame(8'h01, 16, 1'b0, '0, rd);
        chk("R8 next read returns new value", rd, 16'h2222);
        chk("R5 ready high after mid-frame strobe", ready, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule